// File: doc/BRIEF.md
# Multi-Issue In-Order Hazard Checker

This block is the issue decision of a decode stage that handles up to `W` instructions per cycle, strictly in program order. A decode group is loaded into the block. Each slot carries a valid bit, one destination register, two source registers and a two-bit unit class. Every cycle the block works out how many leading instructions of the held group may leave. It compares each slot against all older slots of the same group, and against an externally kept register availability vector that covers instructions already in flight.

Issue always starts at the oldest slot and stops at the first slot that fails any check. The part that does not issue stays in the block, shifted down so that the oldest survivor sits in slot 0. No new group is taken until the held remainder drains. For every issued instruction that writes a nonzero register, the block raises a request to mark that register as pending in the availability vector. Register file, execution units and fetch lie outside the block.

The control is a two-state machine. `GS_EMPTY` means no group is held. `GS_HOLD` means a group, or its remainder, is held. The transitions are:
- **load**: `GS_EMPTY` or `GS_HOLD` to `GS_HOLD`, when `grp_ready` and `in_load` are both high and the new group has a valid slot 0.
- **load-empty**: to `GS_EMPTY`, when a load is accepted but its slot 0 is invalid.
- **drain**: `GS_HOLD` to `GS_EMPTY`, when the whole remainder issues and no load arrives.
- **stall**: `GS_HOLD` to `GS_HOLD`, when part of the remainder stays behind.

Top module: `mih_hazard_chk`

## Requirements
- R1: During and right after reset the block holds no group. `grp_ready` is 1, `issue_cnt` is 0, `issue_mask` is 0 and `clr_req` is 0.
- R2: Slot k occupies bits [k*RW +: RW] of `in_tgt`, `in_src1` and `in_src2`, and bits [2k +: 2] of `in_cls`. Slot 0 is the oldest. A loaded group with no conflicts and distinct classes issues completely in the cycle after the load. `issue_cnt` always equals the number of set bits in `issue_mask`.
- R3: A slot stalls if one of its nonzero sources equals the destination of an older slot in the group (RAW).
- R4: A slot stalls if its nonzero destination equals the destination of an older slot in the group (WAW).
- R5: A slot stalls if its nonzero destination equals a source of an older slot in the group (WAR).
- R6: A slot stalls if a nonzero source or its nonzero destination has its `avail` bit at 0. An `avail` bit of 1 means the register is available. The slot issues once the bit returns to 1.
- R7: Class codes are 0 integer, 1 floating point, 2 branch and 3 load/store. A slot stalls if an older slot in the group has the same class, so at most one instruction of each class issues per group.
- R8: Issue is in program order. `issue_mask` is always a run of ones starting at slot 0. A stalled slot blocks every younger slot. An invalid slot at load ends the group, so younger valid slots are dropped.
- R9: Register 0 never creates a dependence, whether in the group or through `avail[0]`.
- R10: For each issued slot with a nonzero destination r, `clr_req[r]` is 1. No other bit of `clr_req` is set, and bit 0 never is.
- R11: A stalled remainder is held with its oldest slot moved to slot 0, and `grp_ready` is 0 while that remainder cannot fully issue. `in_load` has no effect while `grp_ready` is 0. `grp_ready` is 1 when no group is held, or when the whole remainder issues in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_load | input | 1 | Offer a new decode group |
| in_vld | input | W | Per-slot valid bits of the offered group |
| in_tgt | input | W*RW | Destination register per slot |
| in_src1 | input | W*RW | First source register per slot |
| in_src2 | input | W*RW | Second source register per slot |
| in_cls | input | 2*W | Unit class per slot |
| avail | input | 2**RW | Register availability vector, 1 = available |
| grp_ready | output | 1 | A group offered now is taken at the next edge |
| issue_cnt | output | clog2(W+1) | Number of leading held slots issuing this cycle |
| issue_mask | output | W | Held slots issuing this cycle |
| clr_req | output | 2**RW | Requests to mark registers pending |

## Verification
Some rules can be judged from the outputs alone, so the assertions check them on every cycle. These are the agreement of the count with the mask, the contiguous shape of the mask, the bound on clear requests, the ban on clearing register 0, and the empty idle state after a drain. The individual hazard kinds, the class limit, the effect of the availability vector and register 0, and the shifting of a held remainder depend on the instruction contents. Only the bench scenarios can show those, by comparing counts and clear vectors against values worked out per group.

// File: rtl/mih_pkg.sv
package mih_pkg;
    // Unit class codes carried by every decode slot.
    typedef enum logic [1:0] {
        UC_INT = 2'd0,
        UC_FP  = 2'd1,
        UC_BR  = 2'd2,
        UC_MEM = 2'd3
    } ucls_e;

    // Group holding state.
    typedef enum logic {
        GS_EMPTY = 1'b0,
        GS_HOLD  = 1'b1
    } gstate_e;
endpackage

// File: rtl/mih_pair_cmp.sv
// Conflict between a younger slot and one older slot of the same group.
module mih_pair_cmp #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] y_tgt,
    input  logic [RW-1:0] y_src1,
    input  logic [RW-1:0] y_src2,
    input  logic [1:0]    y_cls,
    input  logic [RW-1:0] o_tgt,
    input  logic [RW-1:0] o_src1,
    input  logic [RW-1:0] o_src2,
    input  logic [1:0]    o_cls,
    output logic          conflict
);
    logic raw_hit, waw_hit, war_hit, cls_hit;

    always_comb begin
        raw_hit = ((y_src1 != '0) && (y_src1 == o_tgt)) ||
                  ((y_src2 != '0) && (y_src2 == o_tgt));
        waw_hit = (y_tgt != '0) && (y_tgt == o_tgt);
        war_hit = (y_tgt != '0) && ((y_tgt == o_src1) || (y_tgt == o_src2));
        cls_hit = (y_cls == o_cls);
        conflict = raw_hit | waw_hit | war_hit | cls_hit;
    end
endmodule

// File: rtl/mih_slot_eval.sv
// Per-slot readiness and in-order issue mask for the held group.
module mih_slot_eval #(
    parameter int W  = 4,
    parameter int RW = 5,
    localparam int NREG = 1 << RW
) (
    input  logic [W-1:0]    h_vld,
    input  logic [W*RW-1:0] h_tgt,
    input  logic [W*RW-1:0] h_src1,
    input  logic [W*RW-1:0] h_src2,
    input  logic [2*W-1:0]  h_cls,
    input  logic [NREG-1:0] avail,
    output logic [W-1:0]    go_mask
);
    logic [W-1:0][W-1:0] cmat;
    logic [W-1:0]        slot_ok;

    for (genvar k = 0; k < W; k++) begin : g_young
        for (genvar j = 0; j < W; j++) begin : g_old
            if (j < k) begin : g_cmp
                mih_pair_cmp #(.RW(RW)) u_cmp (
                    .y_tgt   (h_tgt [k*RW +: RW]),
                    .y_src1  (h_src1[k*RW +: RW]),
                    .y_src2  (h_src2[k*RW +: RW]),
                    .y_cls   (h_cls [2*k +: 2]),
                    .o_tgt   (h_tgt [j*RW +: RW]),
                    .o_src1  (h_src1[j*RW +: RW]),
                    .o_src2  (h_src2[j*RW +: RW]),
                    .o_cls   (h_cls [2*j +: 2]),
                    .conflict(cmat[k][j])
                );
            end else begin : g_none
                assign cmat[k][j] = 1'b0;
            end
        end

        logic [RW-1:0] t_k, s1_k, s2_k;
        logic          pend_k;
        assign t_k  = h_tgt [k*RW +: RW];
        assign s1_k = h_src1[k*RW +: RW];
        assign s2_k = h_src2[k*RW +: RW];
        assign pend_k = ((s1_k != '0) && !avail[s1_k]) ||
                        ((s2_k != '0) && !avail[s2_k]) ||
                        ((t_k  != '0) && !avail[t_k]);
        assign slot_ok[k] = h_vld[k] && !pend_k && !(|cmat[k]);
    end

    always_comb begin
        go_mask[0] = slot_ok[0];
        for (int k = 1; k < W; k++) begin
            go_mask[k] = go_mask[k-1] & slot_ok[k];
        end
    end
endmodule

// File: rtl/mih_group_reg.sv
// Holds the decode group, shifts out issued slots, and gates new loads.
module mih_group_reg
    import mih_pkg::*;
#(
    parameter int W  = 4,
    parameter int RW = 5,
    localparam int CW = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_req,
    input  logic [W-1:0]    in_vld,
    input  logic [W*RW-1:0] in_tgt,
    input  logic [W*RW-1:0] in_src1,
    input  logic [W*RW-1:0] in_src2,
    input  logic [2*W-1:0]  in_cls,
    input  logic [CW-1:0]   iss_cnt,
    output logic [W-1:0]    h_vld,
    output logic [W*RW-1:0] h_tgt,
    output logic [W*RW-1:0] h_src1,
    output logic [W*RW-1:0] h_src2,
    output logic [2*W-1:0]  h_cls,
    output logic            ready
);
    gstate_e state, state_nx;

    logic [W-1:0]    lead_vld;
    logic [CW-1:0]   held_cnt;
    logic            take;
    logic [W-1:0]    vld_nx;
    logic [W*RW-1:0] tgt_nx, src1_nx, src2_nx;
    logic [2*W-1:0]  cls_nx;

    // Valid run from slot 0 of the offered group.
    always_comb begin
        lead_vld[0] = in_vld[0];
        for (int i = 1; i < W; i++) begin
            lead_vld[i] = lead_vld[i-1] & in_vld[i];
        end
    end

    always_comb begin
        held_cnt = '0;
        for (int i = 0; i < W; i++) begin
            held_cnt = held_cnt + CW'(h_vld[i]);
        end
    end

    // Output process.
    always_comb begin
        unique case (state)
            GS_EMPTY: ready = 1'b1;
            GS_HOLD:  ready = (iss_cnt == held_cnt);
            default:  ready = 1'b0;
        endcase
    end

    assign take = ready && ld_req;

    // Next state and next group contents.
    always_comb begin
        state_nx = state;
        vld_nx   = '0;
        tgt_nx   = h_tgt;
        src1_nx  = h_src1;
        src2_nx  = h_src2;
        cls_nx   = h_cls;
        if (take) begin
            vld_nx   = lead_vld;
            tgt_nx   = in_tgt;
            src1_nx  = in_src1;
            src2_nx  = in_src2;
            cls_nx   = in_cls;
            state_nx = lead_vld[0] ? GS_HOLD : GS_EMPTY;
        end else begin
            unique case (state)
                GS_EMPTY: state_nx = GS_EMPTY;
                GS_HOLD: begin
                    for (int i = 0; i < W; i++) begin
                        if (i + int'(iss_cnt) < W) begin
                            vld_nx[i]              = h_vld[i + int'(iss_cnt)];
                            tgt_nx [i*RW +: RW]    = h_tgt [(i + int'(iss_cnt))*RW +: RW];
                            src1_nx[i*RW +: RW]    = h_src1[(i + int'(iss_cnt))*RW +: RW];
                            src2_nx[i*RW +: RW]    = h_src2[(i + int'(iss_cnt))*RW +: RW];
                            cls_nx [2*i +: 2]      = h_cls [2*(i + int'(iss_cnt)) +: 2];
                        end
                    end
                    state_nx = ready ? GS_EMPTY : GS_HOLD;
                end
                default: state_nx = GS_EMPTY;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= GS_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_vld  <= '0;
            h_tgt  <= '0;
            h_src1 <= '0;
            h_src2 <= '0;
            h_cls  <= '0;
        end else begin
            h_vld  <= vld_nx;
            h_tgt  <= tgt_nx;
            h_src1 <= src1_nx;
            h_src2 <= src2_nx;
            h_cls  <= cls_nx;
        end
    end
endmodule

// File: rtl/mih_hazard_chk.sv
// Top: in-order multi-issue hazard checker.
module mih_hazard_chk #(
    parameter int W  = 4,
    parameter int RW = 5,
    localparam int NREG = 1 << RW,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_load,
    input  logic [W-1:0]    in_vld,
    input  logic [W*RW-1:0] in_tgt,
    input  logic [W*RW-1:0] in_src1,
    input  logic [W*RW-1:0] in_src2,
    input  logic [2*W-1:0]  in_cls,
    input  logic [NREG-1:0] avail,
    output logic            grp_ready,
    output logic [CW-1:0]   issue_cnt,
    output logic [W-1:0]    issue_mask,
    output logic [NREG-1:0] clr_req
);
    logic [W-1:0]    h_vld;
    logic [W*RW-1:0] h_tgt, h_src1, h_src2;
    logic [2*W-1:0]  h_cls;
    logic [W-1:0]    go_mask;

    mih_group_reg #(.W(W), .RW(RW)) u_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_req  (in_load),
        .in_vld  (in_vld),
        .in_tgt  (in_tgt),
        .in_src1 (in_src1),
        .in_src2 (in_src2),
        .in_cls  (in_cls),
        .iss_cnt (issue_cnt),
        .h_vld   (h_vld),
        .h_tgt   (h_tgt),
        .h_src1  (h_src1),
        .h_src2  (h_src2),
        .h_cls   (h_cls),
        .ready   (grp_ready)
    );

    mih_slot_eval #(.W(W), .RW(RW)) u_eval (
        .h_vld   (h_vld),
        .h_tgt   (h_tgt),
        .h_src1  (h_src1),
        .h_src2  (h_src2),
        .h_cls   (h_cls),
        .avail   (avail),
        .go_mask (go_mask)
    );

    assign issue_mask = go_mask;

    always_comb begin
        issue_cnt = '0;
        for (int k = 0; k < W; k++) begin
            issue_cnt = issue_cnt + CW'(go_mask[k]);
        end
    end

    always_comb begin
        clr_req = '0;
        for (int k = 0; k < W; k++) begin
            if (go_mask[k] && (h_tgt[k*RW +: RW] != '0)) begin
                clr_req[h_tgt[k*RW +: RW]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mih_hazard_chk_sva.sv
// Port-level properties of the hazard checker, bound to the top.
module mih_hazard_chk_sva #(
    parameter int W  = 4,
    parameter int RW = 5,
    localparam int NREG = 1 << RW,
    localparam int CW   = $clog2(W + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_load,
    input logic            grp_ready,
    input logic [CW-1:0]   issue_cnt,
    input logic [W-1:0]    issue_mask,
    input logic [NREG-1:0] clr_req
);
    logic [W-1:0] mask_inc;
    assign mask_inc = issue_mask + W'(1);

    p_cnt_matches_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(issue_cnt) == $countones(issue_mask));

    // R8: issue mask is a run of ones from slot 0
    p_mask_contiguous_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_inc & issue_mask) == '0);

    p_reg0_never_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req[0]);

    p_clr_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(clr_req) <= int'(issue_cnt));

    // R11: a drained block with no load offered is idle next cycle
    p_idle_after_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ready && !in_load) |=> (grp_ready && issue_cnt == '0));
endmodule

bind mih_hazard_chk mih_hazard_chk_sva #(.W(W), .RW(RW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_load    (in_load),
    .grp_ready  (grp_ready),
    .issue_cnt  (issue_cnt),
    .issue_mask (issue_mask),
    .clr_req    (clr_req)
);

// File: tb/mih_hazard_chk_tb.sv
`timescale 1ns/1ps
module mih_hazard_chk_tb;
    localparam int W = 4;
    localparam int RW = 5;
    localparam int NREG = 1 << RW;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]    vld;
        logic [W*RW-1:0] tgt;
        logic [W*RW-1:0] s1;
        logic [W*RW-1:0] s2;
        logic [2*W-1:0]  cls;
        logic [NREG-1:0] av;
        logic [CW-1:0]   cnt;
        logic [NREG-1:0] clr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TAB [NV] = '{
        // 0 R2: independent, one per class
        '{4'hF, {5'd3,5'd0,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd0,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFF, 3'd4, 32'h0000_000E},
        // 1 R3: slot1 reads slot0 destination
        '{4'hF, {5'd4,5'd3,5'd2,5'd1}, {5'd11,5'd9,5'd1,5'd5}, {5'd12,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFF, 3'd1, 32'h0000_0002},
        // 2 R4: slot2 rewrites slot0 destination
        '{4'hF, {5'd4,5'd1,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd12,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFF, 3'd2, 32'h0000_0006},
        // 3 R5: slot3 writes slot1 source
        '{4'hF, {5'd7,5'd0,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd12,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFF, 3'd3, 32'h0000_0006},
        // 4 R7: two integer slots
        '{4'hF, {5'd4,5'd3,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd12,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd0,2'd0}, 32'hFFFF_FFFF, 3'd1, 32'h0000_0002},
        // 5 R6: slot0 source r5 pending
        '{4'hF, {5'd3,5'd0,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd0,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFDF, 3'd0, 32'h0000_0000},
        // 6 R6: slot1 destination r2 pending
        '{4'hF, {5'd3,5'd0,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd0,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFB, 3'd1, 32'h0000_0002},
        // 7 R9: register 0 everywhere, avail[0] low
        '{4'hF, {5'd3,5'd0,5'd2,5'd0}, {5'd0,5'd0,5'd0,5'd5}, {5'd0,5'd9,5'd0,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFE, 3'd4, 32'h0000_000C},
        // 8 R8: only two valid slots
        '{4'h3, {5'd3,5'd0,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd0,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFF, 3'd2, 32'h0000_0006},
        // 9 R8: gap at slot2 drops slot3
        '{4'hB, {5'd3,5'd0,5'd2,5'd1}, {5'd11,5'd9,5'd7,5'd5}, {5'd0,5'd10,5'd8,5'd6},
          {2'd3,2'd2,2'd1,2'd0}, 32'hFFFF_FFFF, 3'd2, 32'h0000_0006}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_load = 1'b0;
    logic [W-1:0]    in_vld = '0;
    logic [W*RW-1:0] in_tgt = '0, in_src1 = '0, in_src2 = '0;
    logic [2*W-1:0]  in_cls = '0;
    logic [NREG-1:0] avail = '1;
    logic            grp_ready;
    logic [CW-1:0]   issue_cnt;
    logic [W-1:0]    issue_mask;
    logic [NREG-1:0] clr_req;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mih_hazard_chk #(.W(W), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_load(in_load), .in_vld(in_vld),
        .in_tgt(in_tgt), .in_src1(in_src1), .in_src2(in_src2), .in_cls(in_cls),
        .avail(avail), .grp_ready(grp_ready), .issue_cnt(issue_cnt),
        .issue_mask(issue_mask), .clr_req(clr_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_vld = v.vld; in_tgt = v.tgt; in_src1 = v.s1; in_src2 = v.s2; in_cls = v.cls;
    endtask

    // Offer a group at a negedge, apply its avail after the loading edge, sample.
    task automatic load_grp(input vec_t v);
        @(negedge clk);
        drive(v);
        in_load = 1'b1;
        avail = '1;
        @(posedge clk);
        #1;
        in_load = 1'b0;
        avail = v.av;
        #1;
    endtask

    task automatic drain();
        avail = '1;
        repeat (W + 1) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        vec_t junk;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", 32'(grp_ready), 32'd1);
        chk("R1 count in reset", 32'(issue_cnt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after reset", 32'(issue_cnt), 32'd0);
        chk("R1 mask after reset", 32'(issue_mask), 32'd0);
        chk("R1 clr after reset", clr_req, 32'd0);
        chk("R1 ready after reset", 32'(grp_ready), 32'd1);

        // Table walk: R2..R9
        for (int i = 0; i < NV; i++) begin
            load_grp(TAB[i]);
            chk($sformatf("R2-R9 vec %0d count", i), 32'(issue_cnt), 32'(TAB[i].cnt));
            chk($sformatf("R10 vec %0d clr", i), clr_req, TAB[i].clr);
            drain();
        end

        // R11: remainder held and shifted, load ignored while not ready
        load_grp(TAB[1]);
        chk("R11 first count", 32'(issue_cnt), 32'd1);
        chk("R11 not ready", 32'(grp_ready), 32'd0);
        junk = TAB[5];
        drive(junk);
        in_load = 1'b1;
        @(posedge clk);
        #1;
        in_load = 1'b0;
        #1;
        chk("R11 remainder count", 32'(issue_cnt), 32'd3);
        chk("R11 remainder clr", clr_req, 32'h0000_001C);
        chk("R11 ready on drain", 32'(grp_ready), 32'd1);
        @(posedge clk);
        #2;
        chk("R11 empty after drain", 32'(issue_cnt), 32'd0);
        chk("R11 ready when empty", 32'(grp_ready), 32'd1);

        // R6: pending source resolves
        load_grp(TAB[5]);
        chk("R6 blocked", 32'(issue_cnt), 32'd0);
        avail = '1;
        #1;
        chk("R6 released", 32'(issue_cnt), 32'd4);
        chk("R6 released clr", clr_req, 32'h0000_000E);
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule